// File: doc/BRIEF.md
# Byte-Lane Steering and Bus Shifter

This block sits between a 16-bit internal register bus and a 20-bit external-side address/data bus. Each cycle it connects the two buses in one of three ways. In straight mode the register bits sit on the low 16 external bits. In crossover mode the two bytes are exchanged. In shifted mode the external value moves four places right onto the register side, which undoes the four-bit left shift applied to an address-adder result. On the way out, shifted mode appends four zero bits.

Alongside the steering, a small sequencer turns each accepted request into bus transfers. It drives an active-low high-lane enable and the A0 level for each transfer. An aligned word or a single byte takes one transfer. A word at an odd address is never issued as one transfer. It becomes two byte transfers in consecutive cycles: first the high lane at the odd address, then the low lane at the following even address. Memory is little-endian, so the low byte of a word lives at the even address. During both halves of a split, the steering is forced to crossover so that each byte reaches the proper register half. A one-cycle done pulse follows the last transfer of every request.

Top module: `bus_lane_router`

## Requirements
- R1: With `mode` = 00 and no split in progress, `ext_out` = {4'h0, `reg_in`} and `reg_out` = `ext_in[15:0]`, combinationally.
- R2: With `mode` = 01 and no split in progress, both directions exchange bytes: `ext_out` = {4'h0, `reg_in[7:0]`, `reg_in[15:8]`} and `reg_out` = {`ext_in[7:0]`, `ext_in[15:8]`}.
- R3: With `mode` = 10 and no split in progress, `reg_out` = `ext_in[19:4]` and `ext_out` = {`reg_in`, 4'h0}.
- R4: The unused code `mode` = 11 behaves exactly as straight mode (R1).
- R5: A request with `size_word`=1 and `addr_lsb`=0 gives exactly one transfer cycle (`lane_act`=1) in the cycle after the request edge, with `bhe_n`=0 and `a0`=0.
- R6: A byte request (`size_word`=0) gives one transfer cycle in the cycle after the request edge. With `addr_lsb`=0 the lanes are `bhe_n`=1, `a0`=0 (low lane). With `addr_lsb`=1 they are `bhe_n`=0, `a0`=1 (high lane).
- R7: A request with `size_word`=1 and `addr_lsb`=1 gives two consecutive transfer cycles. The first starts in the cycle after the request edge and has `bhe_n`=0, `a0`=1, `second`=0. The second has `bhe_n`=1, `a0`=0, `second`=1.
- R8: In both transfer cycles of a split word, the steering is crossover (as in R2), whatever `mode` holds.
- R9: `done` is high for exactly the one cycle after the last transfer of a request. A request presented in that done cycle is accepted.
- R10: A request presented while `lane_act`=1 is ignored and starts no transfer.
- R11: While in reset and when idle, `lane_act`=0, `done`=0, `second`=0, `bhe_n`=1 and `a0`=0. Reset is synchronous and active high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request strobe, sampled at the rising edge |
| mode | input | 2 | Steering mode: 00 straight, 01 crossover, 10 shift by four, 11 straight |
| size_word | input | 1 | 1 = word request, 0 = byte request |
| addr_lsb | input | 1 | Least significant address bit of the request |
| reg_in | input | 16 | Internal register-bus value heading outward |
| ext_in | input | 20 | External-side bus value heading inward |
| ext_out | output | 20 | Steered value for the external-side bus |
| reg_out | output | 16 | Steered value for the register bus |
| lane_act | output | 1 | A byte or word transfer is on the bus this cycle |
| bhe_n | output | 1 | Active-low high byte-lane enable |
| a0 | output | 1 | Address bit 0 level for the transfer |
| second | output | 1 | Second transfer of a split unaligned word |
| done | output | 1 | One-cycle pulse after the last transfer of a request |

## Verification
The finishing pulse of one request and the acceptance of the next can land in the same cycle. Holding `req` high across several odd-address and aligned word requests forces each new request to be taken in the done cycle of the one before. A second overlap happens when `mode` changes during a split. There, the forced crossover must win over the mode input while the second-phase lane code is on the bus. A behavioural queue model in the bench predicts the lane codes, `second`, `done` and the steered buses, and it is compared with the outputs on every cycle. Directed stretches are followed by a long random stretch.

// File: rtl/blr_pkg.sv
package blr_pkg;

    typedef enum logic [1:0] {
        MD_STRAIGHT = 2'd0,
        MD_CROSS    = 2'd1,
        MD_SHIFT    = 2'd2,
        MD_RSVD     = 2'd3
    } steer_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_ONE      = 3'd1,
        ST_SPLIT_HI = 3'd2,
        ST_SPLIT_LO = 3'd3,
        ST_DONE     = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic bhe_n;
        logic a0;
    } lane_sel_t;

    localparam lane_sel_t SEL_WORD = '{bhe_n: 1'b0, a0: 1'b0};
    localparam lane_sel_t SEL_LOW  = '{bhe_n: 1'b1, a0: 1'b0};
    localparam lane_sel_t SEL_HIGH = '{bhe_n: 1'b0, a0: 1'b1};
    localparam lane_sel_t SEL_IDLE = SEL_LOW;

    // The reserved code folds back to the straight connection.
    function automatic steer_mode_e fold_mode(steer_mode_e m);
        return (m == MD_RSVD) ? MD_STRAIGHT : m;
    endfunction

    function automatic lane_sel_t pick_lanes(logic is_word, logic lsb);
        if (is_word)
            return SEL_WORD;
        return lsb ? SEL_HIGH : SEL_LOW;
    endfunction

    function automatic logic needs_split(logic is_word, logic lsb);
        return is_word & lsb;
    endfunction

endpackage

// File: rtl/blr_steer.sv
module blr_steer
    import blr_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int SHIFT_W = 4
) (
    input  steer_mode_e                  mode_i,
    input  logic                         force_cross_i,
    input  logic [DATA_W-1:0]            reg_i,
    input  logic [DATA_W+SHIFT_W-1:0]    ext_i,
    output logic [DATA_W+SHIFT_W-1:0]    ext_o,
    output logic [DATA_W-1:0]            reg_o
);
    localparam int EXT_W = DATA_W + SHIFT_W;
    localparam int LANES = DATA_W / 8;

    logic [DATA_W-1:0] reg_swapped;
    logic [DATA_W-1:0] ext_swapped;
    steer_mode_e       eff_mode;

    // Lane reversal in both directions.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign reg_swapped[g*8 +: 8] = reg_i[(LANES-1-g)*8 +: 8];
        assign ext_swapped[g*8 +: 8] = ext_i[(LANES-1-g)*8 +: 8];
    end

    assign eff_mode = force_cross_i ? MD_CROSS : fold_mode(mode_i);

    always_comb begin
        unique case (eff_mode)
            MD_CROSS: begin
                ext_o = {{SHIFT_W{1'b0}}, reg_swapped};
                reg_o = ext_swapped;
            end
            MD_SHIFT: begin
                ext_o = {reg_i, {SHIFT_W{1'b0}}};
                reg_o = ext_i[EXT_W-1:SHIFT_W];
            end
            default: begin
                ext_o = {{SHIFT_W{1'b0}}, reg_i};
                reg_o = ext_i[DATA_W-1:0];
            end
        endcase
    end

endmodule

// File: rtl/blr_seq.sv
module blr_seq
    import blr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_i,
    input  logic is_word_i,
    input  logic lsb_i,
    output logic act_o,
    output logic bhe_n_o,
    output logic a0_o,
    output logic second_o,
    output logic done_o,
    output logic split_o
);
    seq_state_e state, nxt;
    lane_sel_t  one_sel;
    lane_sel_t  cur_sel;
    logic       accept;

    assign accept = req_i && (state == ST_IDLE || state == ST_DONE);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE, ST_DONE: begin
                if (accept)
                    nxt = needs_split(is_word_i, lsb_i) ? ST_SPLIT_HI : ST_ONE;
                else
                    nxt = ST_IDLE;
            end
            ST_ONE:      nxt = ST_DONE;
            ST_SPLIT_HI: nxt = ST_SPLIT_LO;
            ST_SPLIT_LO: nxt = ST_DONE;
            default:     nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            one_sel <= SEL_IDLE;
        end else begin
            state <= nxt;
            if (accept)
                one_sel <= pick_lanes(is_word_i, lsb_i);
        end
    end

    always_comb begin
        unique case (state)
            ST_ONE:      cur_sel = one_sel;
            ST_SPLIT_HI: cur_sel = SEL_HIGH;
            ST_SPLIT_LO: cur_sel = SEL_LOW;
            default:     cur_sel = SEL_IDLE;
        endcase
    end

    assign act_o    = (state == ST_ONE) || (state == ST_SPLIT_HI) || (state == ST_SPLIT_LO);
    assign split_o  = (state == ST_SPLIT_HI) || (state == ST_SPLIT_LO);
    assign second_o = (state == ST_SPLIT_LO);
    assign done_o   = (state == ST_DONE);
    assign bhe_n_o  = cur_sel.bhe_n;
    assign a0_o     = cur_sel.a0;

    // R6: an active transfer always enables at least one lane
    a_r6_lane_legal: assert property (@(posedge clk) disable iff (rst)
        act_o |-> !(bhe_n_o && a0_o));

    // R7: the high-lane half of a split is followed by the low-lane half
    a_r7_split_order: assert property (@(posedge clk) disable iff (rst)
        (act_o && split_o && !second_o) |=> (act_o && second_o && bhe_n_o && !a0_o));

    // R9: done comes right after a transfer cycle and lasts one cycle
    a_r9_done_after_last: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ($past(act_o) && !act_o));
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R10: a single transfer lasts one cycle whatever req does
    a_r10_single_one_cycle: assert property (@(posedge clk) disable iff (rst)
        (act_o && !split_o) |=> !act_o);

    // R11: no lane is enabled when idle
    a_r11_idle_lanes: assert property (@(posedge clk) disable iff (rst)
        !act_o |-> (bhe_n_o && !a0_o && !second_o));

endmodule

// File: rtl/bus_lane_router.sv
module bus_lane_router
    import blr_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int SHIFT_W = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req,
    input  logic [1:0]                mode,
    input  logic                      size_word,
    input  logic                      addr_lsb,
    input  logic [DATA_W-1:0]         reg_in,
    input  logic [DATA_W+SHIFT_W-1:0] ext_in,
    output logic [DATA_W+SHIFT_W-1:0] ext_out,
    output logic [DATA_W-1:0]         reg_out,
    output logic                      lane_act,
    output logic                      bhe_n,
    output logic                      a0,
    output logic                      second,
    output logic                      done
);
    localparam int HALF = DATA_W / 2;

    logic split_act;

    blr_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_i     (req),
        .is_word_i (size_word),
        .lsb_i     (addr_lsb),
        .act_o     (lane_act),
        .bhe_n_o   (bhe_n),
        .a0_o      (a0),
        .second_o  (second),
        .done_o    (done),
        .split_o   (split_act)
    );

    blr_steer #(
        .DATA_W  (DATA_W),
        .SHIFT_W (SHIFT_W)
    ) u_steer (
        .mode_i        (steer_mode_e'(mode)),
        .force_cross_i (split_act),
        .reg_i         (reg_in),
        .ext_i         (ext_in),
        .ext_o         (ext_out),
        .reg_o         (reg_out)
    );

    // R8: during a split the register low byte travels on the upper external lane
    a_r8_split_cross: assert property (@(posedge clk) disable iff (rst)
        split_act |-> (ext_out[DATA_W-1:HALF] == reg_in[HALF-1:0]
                       && reg_out[DATA_W-1:HALF] == ext_in[HALF-1:0]));

    // R5: an aligned word request is placed on the bus as one word transfer
    a_r5_word_lanes: assert property (@(posedge clk) disable iff (rst)
        (req && size_word && !addr_lsb && !lane_act) |=> (lane_act && !bhe_n && !a0));

endmodule

// File: tb/bus_lane_router_bench.sv
`timescale 1ns/1ps
module bus_lane_router_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic        size_word = 1'b0;
    logic        addr_lsb = 1'b0;
    logic [15:0] reg_in = 16'h0;
    logic [19:0] ext_in = 20'h0;
    logic [19:0] ext_out;
    logic [15:0] reg_out;
    logic        lane_act, bhe_n, a0, second, done;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    bus_lane_router u_bus_lane_router (
        .clk(clk), .rst(rst), .req(req), .mode(mode),
        .size_word(size_word), .addr_lsb(addr_lsb),
        .reg_in(reg_in), .ext_in(ext_in),
        .ext_out(ext_out), .reg_out(reg_out),
        .lane_act(lane_act), .bhe_n(bhe_n), .a0(a0),
        .second(second), .done(done)
    );

    typedef struct {
        bit    act;
        bit    bhe_n;
        bit    a0;
        bit    second;
        bit    done;
        bit    split;
        string tag;
    } exp_t;

    exp_t q[$];
    exp_t cur;

    function automatic exp_t mk(bit act, bit b, bit a, bit s, bit d, bit sp, string t);
        exp_t e;
        e.act = act; e.bhe_n = b; e.a0 = a; e.second = s; e.done = d; e.split = sp; e.tag = t;
        return e;
    endfunction

    initial cur = mk(0, 1, 0, 0, 0, 0, "R11");

    // Reference model of the transfer sequencing
    always @(posedge clk) begin
        if (rst) begin
            q.delete();
            cur = mk(0, 1, 0, 0, 0, 0, "R11");
        end else begin
            if (req && !cur.act) begin
                if (size_word && addr_lsb) begin
                    q.push_back(mk(1, 0, 1, 0, 0, 1, "R7"));
                    q.push_back(mk(1, 1, 0, 1, 0, 1, "R7"));
                end else if (size_word) begin
                    q.push_back(mk(1, 0, 0, 0, 0, 0, "R5"));
                end else if (addr_lsb) begin
                    q.push_back(mk(1, 0, 1, 0, 0, 0, "R6"));
                end else begin
                    q.push_back(mk(1, 1, 0, 0, 0, 0, "R6"));
                end
                q.push_back(mk(0, 1, 0, 0, 1, 0, "R9"));
            end
            if (q.size() > 0) cur = q.pop_front();
            else              cur = mk(0, 1, 0, 0, 0, 0, "R11");
        end
    end

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        logic [4:0]  exp_l, got_l;
        logic [19:0] ee;
        logic [15:0] er;
        string       st;
        int          m;
        exp_l = {cur.act, cur.bhe_n, cur.a0, cur.second, cur.done};
        got_l = {lane_act, bhe_n, a0, second, done};
        checks++;
        if (got_l !== exp_l) begin
            errors++;
            $display("FAIL %s lanes act/bhe_n/a0/second/done actual=%b expected=%b t=%0t",
                     cur.tag, got_l, exp_l, $time);
        end
        m = cur.split ? 1 : ((mode == 2'd3) ? 0 : int'(mode));
        if (cur.split)           st = "R8";
        else if (mode == 2'd0)   st = "R1";
        else if (mode == 2'd1)   st = "R2";
        else if (mode == 2'd2)   st = "R3";
        else                     st = "R4";
        case (m)
            1: begin ee = {4'h0, reg_in[7:0], reg_in[15:8]}; er = {ext_in[7:0], ext_in[15:8]}; end
            2: begin ee = {reg_in, 4'h0};                    er = ext_in[19:4]; end
            default: begin ee = {4'h0, reg_in};              er = ext_in[15:0]; end
        endcase
        checks++;
        if (ext_out !== ee || reg_out !== er) begin
            errors++;
            $display("FAIL %s steering actual=%h/%h expected=%h/%h t=%0t",
                     st, ext_out, reg_out, ee, er, $time);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic put(bit r, bit [1:0] md, bit w, bit l, bit [15:0] rv, bit [19:0] ev);
        @(posedge clk);
        #2;
        req = r; mode = md; size_word = w; addr_lsb = l; reg_in = rv; ext_in = ev;
    endtask

    task automatic chk(bit cond, string tag, string what, logic [7:0] act_v, logic [7:0] exp_v);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act_v, exp_v);
        end
    endtask

    initial begin
        // R11: reset state
        repeat (2) @(posedge clk);
        #3;
        chk(!lane_act && !done && !second && bhe_n && !a0, "R11", "reset outputs",
            {3'b0, lane_act, bhe_n, a0, second, done}, 8'h08);
        put(0, 0, 0, 0, 16'h0, 20'h0);
        rst = 1'b0;

        // R1 R2 R3 R4: each steering mode with no request
        for (int md = 0; md < 4; md++) begin
            put(0, 2'(md), 0, 0, 16'hA55A, 20'h9C3E1);
            put(0, 2'(md), 0, 0, 16'h1234, 20'hFEDCB);
        end

        // R5: aligned word
        put(1, 0, 1, 0, 16'h0BEE, 20'h12345);
        put(0, 0, 1, 0, 16'h0BEE, 20'h12345);
        repeat (3) put(0, 0, 0, 0, 16'h0, 20'h0);

        // R6: both byte lanes
        put(1, 1, 0, 0, 16'hC0DE, 20'h0F0F0);
        put(0, 1, 0, 0, 16'hC0DE, 20'h0F0F0);
        repeat (2) put(0, 0, 0, 0, 16'h0, 20'h0);
        put(1, 0, 0, 1, 16'hBEEF, 20'hAAAAA);
        put(0, 0, 0, 0, 16'hBEEF, 20'hAAAAA);
        repeat (2) put(0, 0, 0, 0, 16'h0, 20'h0);

        // R7 R8: odd word under straight, then shift changing mid-split
        put(1, 0, 1, 1, 16'h3344, 20'h55667);
        put(0, 0, 1, 1, 16'h3344, 20'h55667);
        put(0, 2, 1, 1, 16'h7788, 20'h99AAB);
        repeat (2) put(0, 2, 0, 0, 16'h7788, 20'h99AAB);
        put(1, 2, 1, 1, 16'h1357, 20'h2468A);
        put(0, 3, 0, 0, 16'h1357, 20'h2468A);
        repeat (3) put(0, 3, 0, 0, 16'h0, 20'h0);

        // R9: req held high, next request taken in each done cycle
        for (int k = 0; k < 12; k++)
            put(1, 2'(k % 3), 1, 1'(k % 2), 16'(k * 16'h1111), 20'(k * 20'h0F0F1));
        repeat (3) put(0, 0, 0, 0, 16'h0, 20'h0);

        // R10: request during an active transfer is ignored
        put(1, 0, 1, 0, 16'h4242, 20'h0);
        put(1, 0, 0, 1, 16'h4242, 20'h0);
        put(0, 0, 0, 0, 16'h4242, 20'h0);
        #1;
        chk(!lane_act && done, "R10", "act/done after ignored request",
            {6'b0, lane_act, done}, 8'h01);
        repeat (2) put(0, 0, 0, 0, 16'h0, 20'h0);

        // Random stretch covering all requirements
        for (int k = 0; k < 4000; k++)
            put(1'($urandom_range(0, 2) == 0), 2'($urandom), 1'($urandom), 1'($urandom),
                16'($urandom), 20'($urandom));
        repeat (4) put(0, 0, 0, 0, 16'h0, 20'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule